// File: doc/BRIEF.md
# Configuration Readback CRC Scrubber

This block guards the configuration memory of several SRAM-programmed logic devices against single-event upsets. It walks through the devices one after another and, inside each device, through its configuration frames in ascending order. Each frame arrives as a stream of bytes on an 8-bit readback port. A byte-serial CRC-32 engine folds the stream into a signature, and that signature is compared with a golden value held in an external codebook SRAM.

When the signature and the golden value agree, the controller moves straight on to the next frame. When they disagree, the controller stops and raises an interrupt. It then freezes a report for the host: which device and frame, how many frames each device has, the expected and the computed CRC, and the bytes of the faulty frame. The host repairs that single frame by partial reconfiguration and then writes an acknowledge, and scanning resumes with the following frame.

The host reaches the block through a 32-bit register port that carries a parity bit.

Top module: `frame_crc_scrubber`

## Requirements
- R1: After reset, `irq`, `rb_active` and `cb_rd` are low and the status register (word 1) reads 0.
- R2: Frames are visited in the order frame 0 up to FRAMES_PER_DEV-1 of device 0, then of device 1, and so on up to NUM_DEV-1, then back to device 0 frame 0. `rb_dev` and `rb_frame` name the frame being read while `rb_active` is high.
- R3: The signature is CRC-32, polynomial 0x04C11DB7, most significant bit first, seeded with all ones at the first byte of each frame, with no final inversion. Exactly one byte is taken on each cycle in which `rb_valid` and `rb_active` are both high. A frame whose signature equals its golden value raises no interrupt, and scanning continues.
- R4: For each frame, `cb_rd` pulses for one cycle with `cb_addr` = device × FRAMES_PER_DEV + frame. `cb_rdata` is taken on the cycle after the pulse.
- R5: On a mismatch, `irq` goes high, and `rb_active` and `cb_rd` stay low until the host acknowledges.
- R6: While halted, word 3 reads {8'h00, device[7:0], frame[15:0]}, word 4 reads FRAMES_PER_DEV, word 5 reads the golden CRC, and word 6 reads the computed CRC.
- R7: Word 7 holds a byte index (writable). Word 8 returns, in bits 7:0, that byte of the frame that failed.
- R8: A write to word 2 with bit 0 set releases a halt, and scanning resumes at the next frame in the R2 order. The same write arriving in any cycle when the block is not halted, including the comparison cycle itself, has no effect.
- R9: Host writes use even parity: `host_wpar` must equal the XOR of `host_wdata`. A write with wrong parity changes nothing and sets status bit 1. Writing word 2 with bit 1 set clears that bit. `host_rpar` is the XOR of `host_rdata`. Status bit 0 is high while halted.
- R10: Bit 0 of word 0 enables scanning. Clearing it lets the frame in progress finish, and no further frame starts. Bytes presented while `rb_active` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rb_active | output | 1 | Readback of a frame in progress; bytes are accepted |
| rb_dev | output | DEV_W | Device being read back |
| rb_frame | output | FR_W | Frame being read back |
| rb_valid | input | 1 | Readback byte valid |
| rb_data | input | 8 | Readback byte |
| cb_rd | output | 1 | Codebook read strobe |
| cb_addr | output | CB_AW | Codebook address |
| cb_rdata | input | 32 | Golden CRC, one cycle after the strobe |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host write (else read) |
| host_addr | input | 4 | Register word index |
| host_wdata | input | 32 | Host write data |
| host_wpar | input | 1 | Even parity of write data |
| host_rdata | output | 32 | Register read data |
| host_rpar | output | 1 | Even parity of read data |
| irq | output | 1 | Mismatch interrupt, high while halted |

## Verification
Two of the block's functions can coincide in one cycle: the host's acknowledge path and the comparison that detects a mismatch. The bench provokes this by timing a well-formed acknowledge write to land on the exact cycle in which the codebook word is compared, on a frame whose golden value has been corrupted. It then judges the result by checking that `irq` is still high afterwards and that a later acknowledge is still needed to resume.

A second overlap is a write with bad parity to the acknowledge register while the block is halted. Here the bench checks both that the halt holds and that the parity flag is set in the same access.

// File: rtl/scrub_pkg.sv
package scrub_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_READ,
      S_LOOK,
      S_CMP,
      S_HALT
   } scan_st_t;

   localparam logic [3:0] RG_CTRL  = 4'd0;
   localparam logic [3:0] RG_STAT  = 4'd1;
   localparam logic [3:0] RG_ACK   = 4'd2;
   localparam logic [3:0] RG_LOC   = 4'd3;
   localparam logic [3:0] RG_NFRM  = 4'd4;
   localparam logic [3:0] RG_EXP   = 4'd5;
   localparam logic [3:0] RG_ACT   = 4'd6;
   localparam logic [3:0] RG_DIDX  = 4'd7;
   localparam logic [3:0] RG_DATA  = 4'd8;

   // one byte folded MSB first into a CRC-32 register
   function automatic logic [31:0] crc_fold(input logic [31:0] seed,
                                            input logic [7:0]  b,
                                            input logic [31:0] poly);
      logic [31:0] c;
      c = seed ^ {b, 24'h0};
      for (int k = 0; k < 8; k++)
         c = c[31] ? ((c << 1) ^ poly) : (c << 1);
      return c;
   endfunction

endpackage

// File: rtl/scrub_crc.sv
module scrub_crc #(
   parameter logic [31:0] POLY = 32'h04C1_1DB7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        take,
   input  logic        first,
   input  logic [7:0]  din,
   output logic [31:0] crc
);
   import scrub_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n)
         crc <= '1;
      else if (take)
         crc <= crc_fold(first ? 32'hFFFF_FFFF : crc, din, POLY);
   end

endmodule

// File: rtl/scrub_fbuf.sv
module scrub_fbuf #(
   parameter int FRAME_BYTES = 8,
   parameter bit KEEP_DATA   = 1'b1,
   localparam int BYTE_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1
) (
   input  logic              clk,
   input  logic              we,
   input  logic [BYTE_W-1:0] waddr,
   input  logic [7:0]        wdata,
   input  logic [BYTE_W-1:0] raddr,
   output logic [7:0]        rdata
);
   generate
      if (KEEP_DATA) begin : g_keep
         logic [7:0] mem [FRAME_BYTES];
         always_ff @(posedge clk) begin
            if (we)
               mem[waddr] <= wdata;
         end
         assign rdata = (int'(raddr) < FRAME_BYTES) ? mem[raddr] : 8'h00;
      end else begin : g_drop
         logic unused;
         assign unused = clk ^ we ^ (^waddr) ^ (^wdata) ^ (^raddr);
         assign rdata  = 8'h00;
      end
   endgenerate

endmodule

// File: rtl/scrub_seq.sv
module scrub_seq #(
   parameter int NUM_DEV        = 3,
   parameter int FRAMES_PER_DEV = 4,
   parameter int FRAME_BYTES    = 8,
   localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int FR_W   = (FRAMES_PER_DEV > 1) ? $clog2(FRAMES_PER_DEV) : 1,
   localparam int BYTE_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
   localparam int CB_AW  = (NUM_DEV * FRAMES_PER_DEV > 1) ?
                           $clog2(NUM_DEV * FRAMES_PER_DEV) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              ack,
   input  logic              rb_valid,
   input  logic [31:0]       crc,
   input  logic [31:0]       cb_rdata,
   output logic              rb_active,
   output logic [DEV_W-1:0]  dev,
   output logic [FR_W-1:0]   frame,
   output logic              cb_rd,
   output logic [CB_AW-1:0]  cb_addr,
   output logic              take,
   output logic              first,
   output logic [BYTE_W-1:0] byte_idx,
   output logic              halted,
   output logic [DEV_W-1:0]  rep_dev,
   output logic [FR_W-1:0]   rep_frame,
   output logic [31:0]       rep_exp,
   output logic [31:0]       rep_act
);
   import scrub_pkg::*;

   localparam logic [BYTE_W-1:0] LAST_B = BYTE_W'(FRAME_BYTES - 1);
   localparam logic [FR_W-1:0]   LAST_F = FR_W'(FRAMES_PER_DEV - 1);
   localparam logic [DEV_W-1:0]  LAST_D = DEV_W'(NUM_DEV - 1);

   scan_st_t st;

   assign rb_active = (st == S_READ);
   assign cb_rd     = (st == S_LOOK);
   assign halted    = (st == S_HALT);
   assign take      = rb_active && rb_valid;
   assign first     = (byte_idx == '0);
   assign cb_addr   = CB_AW'(dev) * CB_AW'(FRAMES_PER_DEV) + CB_AW'(frame);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         dev       <= '0;
         frame     <= '0;
         byte_idx  <= '0;
         rep_dev   <= '0;
         rep_frame <= '0;
         rep_exp   <= '0;
         rep_act   <= '0;
      end else begin
         case (st)
            S_IDLE: if (enable) st <= S_READ;
            S_READ: if (rb_valid) begin
               if (byte_idx == LAST_B) begin
                  byte_idx <= '0;
                  st       <= S_LOOK;
               end else begin
                  byte_idx <= byte_idx + 1'b1;
               end
            end
            S_LOOK: st <= S_CMP;
            S_CMP, S_HALT: begin
               if (st == S_CMP && cb_rdata != crc) begin
                  st        <= S_HALT;
                  rep_dev   <= dev;
                  rep_frame <= frame;
                  rep_exp   <= cb_rdata;
                  rep_act   <= crc;
               end else if (st == S_CMP || ack) begin
                  st <= enable ? S_READ : S_IDLE;
                  if (frame == LAST_F) begin
                     frame <= '0;
                     dev   <= (dev == LAST_D) ? '0 : dev + 1'b1;
                  end else begin
                     frame <= frame + 1'b1;
                  end
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assert_position_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(frame) < FRAMES_PER_DEV) && (int'(dev) < NUM_DEV));

   assert_cb_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cb_rd |=> !cb_rd);

   assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (halted && !ack) |=> (halted && !rb_active));

   assert_report_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(rep_exp) && $stable(rep_act) && $stable(rep_frame)));

endmodule

// File: rtl/scrub_regs.sv
module scrub_regs #(
   parameter int FRAMES_PER_DEV = 4,
   parameter int DEV_W  = 2,
   parameter int FR_W   = 2,
   parameter int BYTE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [3:0]        host_addr,
   input  logic [31:0]       host_wdata,
   input  logic              host_wpar,
   output logic [31:0]       host_rdata,
   output logic              host_rpar,
   input  logic              halted,
   input  logic [DEV_W-1:0]  rep_dev,
   input  logic [FR_W-1:0]   rep_frame,
   input  logic [31:0]       rep_exp,
   input  logic [31:0]       rep_act,
   input  logic [7:0]        fbyte,
   output logic              enable,
   output logic              ack,
   output logic [BYTE_W-1:0] didx
);
   import scrub_pkg::*;

   logic par_ok, wr_ok, par_err;

   assign par_ok = ((^host_wdata) == host_wpar);
   assign wr_ok  = host_sel && host_wr && par_ok;
   assign ack    = wr_ok && (host_addr == RG_ACK) && host_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable  <= 1'b0;
         par_err <= 1'b0;
         didx    <= '0;
      end else begin
         if (host_sel && host_wr && !par_ok)
            par_err <= 1'b1;
         else if (wr_ok && host_addr == RG_ACK && host_wdata[1])
            par_err <= 1'b0;
         if (wr_ok && host_addr == RG_CTRL)
            enable <= host_wdata[0];
         if (wr_ok && host_addr == RG_DIDX)
            didx <= host_wdata[BYTE_W-1:0];
      end
   end

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         RG_CTRL: host_rdata = {31'h0, enable};
         RG_STAT: host_rdata = {30'h0, par_err, halted};
         RG_LOC:  host_rdata = {8'h00, 8'(rep_dev), 16'(rep_frame)};
         RG_NFRM: host_rdata = 32'(FRAMES_PER_DEV);
         RG_EXP:  host_rdata = rep_exp;
         RG_ACT:  host_rdata = rep_act;
         RG_DIDX: host_rdata = 32'(didx);
         RG_DATA: host_rdata = {24'h0, fbyte};
         default: host_rdata = '0;
      endcase
   end

   assign host_rpar = ^host_rdata;

   assert_bad_par_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_sel && host_wr && !par_ok) |=> ($stable(enable) && $stable(didx) && par_err));

endmodule

// File: rtl/frame_crc_scrubber.sv
module frame_crc_scrubber #(
   parameter int          NUM_DEV        = 3,
   parameter int          FRAMES_PER_DEV = 4,
   parameter int          FRAME_BYTES    = 8,
   parameter bit          KEEP_DATA      = 1'b1,
   parameter logic [31:0] POLY           = 32'h04C1_1DB7,
   localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
   localparam int FR_W   = (FRAMES_PER_DEV > 1) ? $clog2(FRAMES_PER_DEV) : 1,
   localparam int BYTE_W = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1,
   localparam int CB_AW  = (NUM_DEV * FRAMES_PER_DEV > 1) ?
                           $clog2(NUM_DEV * FRAMES_PER_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             rb_active,
   output logic [DEV_W-1:0] rb_dev,
   output logic [FR_W-1:0]  rb_frame,
   input  logic             rb_valid,
   input  logic [7:0]       rb_data,
   output logic             cb_rd,
   output logic [CB_AW-1:0] cb_addr,
   input  logic [31:0]      cb_rdata,
   input  logic             host_sel,
   input  logic             host_wr,
   input  logic [3:0]       host_addr,
   input  logic [31:0]      host_wdata,
   input  logic             host_wpar,
   output logic [31:0]      host_rdata,
   output logic             host_rpar,
   output logic             irq
);

   generate
      if (NUM_DEV < 1 || NUM_DEV > 256) begin : g_bad_dev
         $error("NUM_DEV must lie in 1..256");
      end
      if (FRAMES_PER_DEV < 1 || FRAMES_PER_DEV > 65536) begin : g_bad_frm
         $error("FRAMES_PER_DEV must lie in 1..65536");
      end
      if (FRAME_BYTES < 2) begin : g_bad_len
         $error("FRAME_BYTES must be at least 2");
      end
   endgenerate

   logic              enable, ack, take, first, halted;
   logic [BYTE_W-1:0] byte_idx, didx;
   logic [31:0]       crc, rep_exp, rep_act;
   logic [DEV_W-1:0]  rep_dev;
   logic [FR_W-1:0]   rep_frame;
   logic [7:0]        fbyte;

   scrub_seq #(
      .NUM_DEV(NUM_DEV), .FRAMES_PER_DEV(FRAMES_PER_DEV), .FRAME_BYTES(FRAME_BYTES)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ack(ack), .rb_valid(rb_valid),
      .crc(crc), .cb_rdata(cb_rdata), .rb_active(rb_active), .dev(rb_dev),
      .frame(rb_frame), .cb_rd(cb_rd), .cb_addr(cb_addr), .take(take),
      .first(first), .byte_idx(byte_idx), .halted(halted), .rep_dev(rep_dev),
      .rep_frame(rep_frame), .rep_exp(rep_exp), .rep_act(rep_act)
   );

   scrub_crc #(.POLY(POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .take(take), .first(first), .din(rb_data), .crc(crc)
   );

   scrub_fbuf #(.FRAME_BYTES(FRAME_BYTES), .KEEP_DATA(KEEP_DATA)) u_fbuf (
      .clk(clk), .we(take), .waddr(byte_idx), .wdata(rb_data),
      .raddr(didx), .rdata(fbyte)
   );

   scrub_regs #(
      .FRAMES_PER_DEV(FRAMES_PER_DEV), .DEV_W(DEV_W), .FR_W(FR_W), .BYTE_W(BYTE_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_wpar(host_wpar),
      .host_rdata(host_rdata), .host_rpar(host_rpar), .halted(halted),
      .rep_dev(rep_dev), .rep_frame(rep_frame), .rep_exp(rep_exp),
      .rep_act(rep_act), .fbyte(fbyte), .enable(enable), .ack(ack), .didx(didx)
   );

   assign irq = halted;

   assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (!rb_active && !cb_rd));

endmodule

// File: tb/frame_crc_scrubber_tb.sv
module frame_crc_scrubber_tb;

   localparam int ND = 3;
   localparam int NF = 4;
   localparam int NB = 8;
   localparam logic [31:0] POLY = 32'h04C1_1DB7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rb_active, rb_valid = 1'b0;
   logic [1:0]  rb_dev, rb_frame;
   logic [7:0]  rb_data = 8'h00;
   logic        cb_rd;
   logic [3:0]  cb_addr;
   logic [31:0] cb_rdata = '0;
   logic        host_sel = 1'b0, host_wr = 1'b0, host_wpar = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [31:0] host_wdata = '0, host_rdata;
   logic        host_rpar, irq;

   frame_crc_scrubber #(.NUM_DEV(ND), .FRAMES_PER_DEV(NF), .FRAME_BYTES(NB)) u_dut (
      .clk(clk), .rst_n(rst_n), .rb_active(rb_active), .rb_dev(rb_dev),
      .rb_frame(rb_frame), .rb_valid(rb_valid), .rb_data(rb_data), .cb_rd(cb_rd),
      .cb_addr(cb_addr), .cb_rdata(cb_rdata), .host_sel(host_sel), .host_wr(host_wr),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_wpar(host_wpar),
      .host_rdata(host_rdata), .host_rpar(host_rpar), .irq(irq)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] cb_mem [ND*NF];
   int exp_q [$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   function automatic logic [7:0] byte_of(input int d, input int f, input int i);
      return 8'(d * 37 + f * 11 + i * 5 + 1);
   endfunction

   function automatic logic [31:0] fold(input logic [31:0] c0, input logic [7:0] b);
      logic [31:0] c;
      c = c0 ^ {b, 24'h0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ POLY) : (c << 1);
      return c;
   endfunction

   function automatic logic [31:0] golden(input int d, input int f);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < NB; i++) c = fold(c, byte_of(d, f, i));
      return c;
   endfunction

   // codebook SRAM, one cycle read latency
   always @(posedge clk) if (cb_rd) cb_rdata <= cb_mem[cb_addr];

   // scoreboard monitor: each codebook strobe must match the next expected address (R4)
   always @(negedge clk) begin
      if (rst_n && cb_rd) begin
         if (exp_q.size() == 0) check("R4 unexpected cb_rd", 32'(cb_addr), 32'hFFFF_FFFF);
         else check("R4 codebook address", 32'(cb_addr), 32'(exp_q.pop_front()));
      end
   end

   task automatic hwrite(input logic [3:0] a, input logic [31:0] d, input bit bad);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
      host_wpar = (^d) ^ bad;
      @(posedge clk);
      #1 host_sel = 1'b0; host_wr = 1'b0;
   endtask

   task automatic hread(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
      #1 d = host_rdata;
      check("R9 read parity", 32'(host_rpar), 32'(^host_rdata));
      host_sel = 1'b0;
   endtask

   // driver: waits for the frame, pushes the expected codebook address, streams bytes
   task automatic run_frame(input int d, input int f, input logic [7:0] mask,
                            input bit ack_same, output logic [31:0] act);
      logic [7:0] b;
      act = 32'hFFFF_FFFF;
      while (!rb_active) @(negedge clk);
      check("R2 device order", 32'(rb_dev), 32'(d));
      check("R2 frame order", 32'(rb_frame), 32'(f));
      exp_q.push_back(d * NF + f);
      for (int i = 0; i < NB; i++) begin
         b = byte_of(d, f, i) ^ ((i == 3) ? mask : 8'h00);
         act = fold(act, b);
         @(negedge clk);
         rb_valid = 1'b1; rb_data = b;
         @(posedge clk);
      end
      @(negedge clk);
      rb_valid = 1'b0;
      @(posedge clk);
      if (ack_same) begin
         // acknowledge lands in the comparison cycle (R8)
         @(negedge clk);
         host_sel = 1'b1; host_wr = 1'b1; host_addr = 4'd2; host_wdata = 32'h1;
         host_wpar = 1'b1;
         @(posedge clk);
         #1 host_sel = 1'b0; host_wr = 1'b0;
      end else begin
         @(posedge clk);
      end
      @(negedge clk);
   endtask

   task automatic handle_error(input int d, input int f, input logic [31:0] act,
                               input logic [7:0] mask);
      logic [31:0] r;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         check("R5 halted quiet", {30'h0, rb_active, cb_rd}, 32'h0);
      end
      hread(4'd3, r); check("R6 location", r, {8'h00, 8'(d), 16'(f)});
      hread(4'd4, r); check("R6 frame count", r, 32'(NF));
      hread(4'd5, r); check("R6 expected crc", r, cb_mem[d * NF + f]);
      hread(4'd6, r); check("R6 actual crc", r, act);
      hwrite(4'd7, 32'd3, 1'b0);
      hread(4'd8, r); check("R7 frame byte 3", r, 32'(byte_of(d, f, 3) ^ mask));
      hwrite(4'd7, 32'd7, 1'b0);
      hread(4'd8, r); check("R7 frame byte 7", r, 32'(byte_of(d, f, 7)));
      hread(4'd1, r); check("R9 status halted", r, 32'h1);
      hwrite(4'd2, 32'h1, 1'b1);
      @(negedge clk);
      check("R9 bad parity ack ignored", 32'(irq), 32'h1);
      hread(4'd1, r); check("R9 parity flag set", r, 32'h3);
      hwrite(4'd2, 32'h3, 1'b0);
      @(negedge clk);
      check("R8 ack releases", 32'(irq), 32'h0);
      hread(4'd1, r); check("R9 status cleared", r, 32'h0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      logic [31:0] r, act;
      logic [7:0] mask;
      bit mis;
      for (int i = 0; i < ND * NF; i++) cb_mem[i] = golden(i / NF, i % NF);
      cb_mem[1 * NF + 1] ^= 32'h0000_0100;
      cb_mem[0 * NF + 3] ^= 32'h8000_0000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset outputs", {29'h0, irq, rb_active, cb_rd}, 32'h0);
      hread(4'd1, r); check("R1 reset status", r, 32'h0);

      hwrite(4'd0, 32'h1, 1'b0);
      for (int d = 0; d < ND; d++) begin
         for (int f = 0; f < NF; f++) begin
            mask = (d == 2 && f == 2) ? 8'h40 : 8'h00;
            mis  = (d == 1 && f == 1) || (d == 0 && f == 3) || (mask != 0);
            run_frame(d, f, mask, (d == 0 && f == 3), act);
            if (d == 0 && f == 3) begin
               repeat (2) @(negedge clk);
               check("R8 ack in compare cycle ignored", 32'(irq), 32'h1);
            end
            check(mis ? "R5 mismatch irq" : "R3 match no irq", 32'(irq), 32'(mis));
            if (mis) handle_error(d, f, act, mask);
         end
      end
      run_frame(0, 0, 8'h00, 1'b0, act);
      check("R2 wrap no irq", 32'(irq), 32'h0);

      // disable during the next frame: it finishes, no further frame starts
      while (!rb_active) @(negedge clk);
      hwrite(4'd0, 32'h0, 1'b0);
      run_frame(0, 1, 8'h00, 1'b0, act);
      check("R10 last frame clean", 32'(irq), 32'h0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         rb_valid = 1'b1; rb_data = 8'hA5;
         check("R10 stopped after disable", {30'h0, rb_active, cb_rd}, 32'h0);
      end
      @(negedge clk) rb_valid = 1'b0;
      hwrite(4'd0, 32'h1, 1'b0);
      run_frame(0, 2, 8'h00, 1'b0, act);
      check("R10 idle bytes ignored", 32'(irq), 32'h0);
      hwrite(4'd0, 32'h0, 1'b0);
      repeat (12) @(negedge clk);
      check("R4 all strobes seen", 32'(exp_q.size()), 32'h0);
      summary();
   end

endmodule